// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sits beside the program counter of a small signal-processing core. It repeats a run of instructions a set number of times without spending any cycle on a branch. A loop-start strobe gives the address of the first body instruction, the address of the last body instruction and an iteration count. The block keeps the count and the last-address value in plain registers. It pushes the first-body address onto a two-entry hardware stack. Each cycle it compares the fetch address against the last-address register and returns the address of the next fetch.

When the last instruction of the body is fetched and the count is not one, the block decrements the count and sends fetch back to the address on top of the stack. When the count is one, fetch falls through to the next address. The block then drops one stack entry and reloads its loop-active flag from a saved nesting bit.

The count and last-address registers are never saved or restored by the hardware. Software nests loops by saving and reloading them over a 16-bit move bus, on which the count occupies the low 13 bits.

Top module: `hwloop_seq`

## Requirements
- R1: After reset the count and last-address registers read 0, the loop-active flag and nesting bit are 0, the stack is empty (level 0) and the stack-error flag is 0.
- R2: A count read returns the 13-bit count in bus bits 12:0 with bits 15:13 as zero. A count write stores bus bits 12:0 and ignores bits 15:13.
- R3: The last-address register is loaded from the loop-start strobe and can also be written and read whole through the move bus.
- R4: `next_pc` equals `fetch_addr + 1` whenever the loop-active flag is clear, `fetch_en` is low, or the fetch address differs from the last-address register. In these cases the count does not change.
- R5: When an enabled fetch hits the last address while the flag is set and the count is not 1, `next_pc` is the stack top and the count drops by one at the next edge.
- R6: When such a hit happens with the count equal to 1, `next_pc` is `fetch_addr + 1`. At the next edge the flag takes the nesting bit's value and the stack level drops by one.
- R7: A loop start copies the flag into the nesting bit, sets the flag, pushes the first-body address, and loads the count and last-address registers.
- R8: A loop start with a count of 0 loads a count of 1, so the body runs once.
- R9: A push to a full stack or a pop from an empty stack sets the sticky stack-error flag and leaves the stack level and contents unchanged.
- R10: A loop start in the same cycle as a last-address hit takes precedence, and the hit's pop or decrement does not happen. A move-bus count write in the same cycle as a repeating hit stores the bus value instead of the decremented count.
- R11: Leaving an inner loop does not restore the outer loop's count or last address. Both keep the inner loop's final values until software rewrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en | input | 1 | A fetch occurs this cycle at `fetch_addr` |
| fetch_addr | input | 16 | Current fetch address |
| next_pc | output | 16 | Address of the next fetch |
| do_start | input | 1 | Loop-start strobe |
| do_first | input | 16 | First body address pushed on loop start |
| do_last | input | 16 | Last body address loaded on loop start |
| do_count | input | 13 | Iteration count loaded on loop start |
| cnt_wr | input | 1 | Move-bus write to the count register |
| end_wr | input | 1 | Move-bus write to the last-address register |
| mv_wdata | input | 16 | Move-bus write data |
| cnt_rdata | output | 16 | Count register as seen on the move bus |
| end_rdata | output | 16 | Last-address register as seen on the move bus |
| loop_flag | output | 1 | Loop-active flag |
| nest_flag | output | 1 | Saved nesting bit |
| stk_level | output | 2 | Number of occupied stack entries |
| stk_err | output | 1 | Sticky stack-error flag |

## Verification
A single loop of count three is walked through its body. This separates plain incrementing on body addresses, the jump back on the final address, and the fall-through once the count reaches one. A count of zero shows whether the body runs exactly once rather than wrapping to 8191. A loop nested inside a loop shows that the flag comes back from the nesting bit while the count and last address stay with the inner values. A third push and a pop on an empty stack each set the sticky error without disturbing the stack. Same-cycle collisions of a start or a count write with a last-address hit show which action wins.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
   typedef enum logic [1:0] {
      ACT_IDLE   = 2'd0,
      ACT_START  = 2'd1,
      ACT_REPEAT = 2'd2,
      ACT_EXIT   = 2'd3
   } loop_act_e;
endpackage

// File: rtl/hwloop_stack.sv
module hwloop_stack #(
   parameter int DEPTH = 2,
   parameter int W     = 16,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     top,
   output logic [LVL_W-1:0] level,
   output logic             err
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("hwloop_stack: DEPTH must be at least 1");
   end

   logic [DEPTH-1:0][W-1:0] slots;
   logic                    full;
   logic                    empty;

   assign full  = (level == LVL_W'(DEPTH));
   assign empty = (level == '0);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [W-1:0] ent;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent <= '0;
         else if (push && !full && level == LVL_W'(i))
            ent <= din;
      end
      assign slots[i] = ent;
   end

   always_comb begin
      top = '0;
      for (int i = 0; i < DEPTH; i++)
         if (level == LVL_W'(i + 1))
            top = slots[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
         err   <= 1'b0;
      end else begin
         if (push && !full)
            level <= level + 1'b1;
         else if (pop && !empty)
            level <= level - 1'b1;
         if ((push && full) || (pop && empty))
            err <= 1'b1;
      end
   end
endmodule

// File: rtl/hwloop_regs.sv
module hwloop_regs
   import hwloop_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 13,
   parameter int BUS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  loop_act_e         act,
   input  logic [ADDR_W-1:0] do_last,
   input  logic [CNT_W-1:0]  do_count,
   input  logic              cnt_wr,
   input  logic              end_wr,
   input  logic [BUS_W-1:0]  mv_wdata,
   output logic [CNT_W-1:0]  count,
   output logic [ADDR_W-1:0] end_addr,
   output logic [BUS_W-1:0]  cnt_rdata,
   output logic [BUS_W-1:0]  end_rdata
);
   localparam int CNT_PAD = BUS_W - CNT_W;

   logic [CNT_W-1:0] start_cnt;

   assign start_cnt = (do_count == '0) ? CNT_W'(1) : do_count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (act == ACT_START)
         count <= start_cnt;
      else if (cnt_wr)
         count <= mv_wdata[CNT_W-1:0];
      else if (act == ACT_REPEAT)
         count <= count - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         end_addr <= '0;
      else if (act == ACT_START)
         end_addr <= do_last;
      else if (end_wr)
         end_addr <= mv_wdata[ADDR_W-1:0];
   end

   if (CNT_PAD > 0) begin : g_cnt_pad
      assign cnt_rdata = {{CNT_PAD{1'b0}}, count};
   end else begin : g_cnt_full
      assign cnt_rdata = count;
   end

   if (BUS_W > ADDR_W) begin : g_end_pad
      assign end_rdata = {{(BUS_W - ADDR_W){1'b0}}, end_addr};
   end else begin : g_end_full
      assign end_rdata = end_addr;
   end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
   import hwloop_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_en,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [ADDR_W-1:0] end_addr,
   input  logic [CNT_W-1:0]  count,
   input  logic              do_start,
   input  logic [ADDR_W-1:0] stk_top,
   output loop_act_e         act,
   output logic [ADDR_W-1:0] next_pc,
   output logic              loop_flag,
   output logic              nest_flag
);
   logic hit;
   logic last_pass;

   assign hit       = fetch_en && loop_flag && (fetch_addr == end_addr);
   assign last_pass = (count == CNT_W'(1));

   always_comb begin
      if (do_start)
         act = ACT_START;
      else if (hit)
         act = last_pass ? ACT_EXIT : ACT_REPEAT;
      else
         act = ACT_IDLE;
   end

   assign next_pc = (act == ACT_REPEAT) ? stk_top : fetch_addr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loop_flag <= 1'b0;
         nest_flag <= 1'b0;
      end else begin
         case (act)
            ACT_START: begin
               nest_flag <= loop_flag;
               loop_flag <= 1'b1;
            end
            ACT_EXIT:  loop_flag <= nest_flag;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
   import hwloop_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 13,
   parameter int BUS_W     = 16,
   parameter int STK_DEPTH = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           fetch_en,
   input  logic [ADDR_W-1:0]              fetch_addr,
   output logic [ADDR_W-1:0]              next_pc,
   input  logic                           do_start,
   input  logic [ADDR_W-1:0]              do_first,
   input  logic [ADDR_W-1:0]              do_last,
   input  logic [CNT_W-1:0]               do_count,
   input  logic                           cnt_wr,
   input  logic                           end_wr,
   input  logic [BUS_W-1:0]               mv_wdata,
   output logic [BUS_W-1:0]               cnt_rdata,
   output logic [BUS_W-1:0]               end_rdata,
   output logic                           loop_flag,
   output logic                           nest_flag,
   output logic [$clog2(STK_DEPTH+1)-1:0] stk_level,
   output logic                           stk_err
);
   if (CNT_W > BUS_W) begin : g_bad_cnt
      $error("hwloop_seq: CNT_W exceeds BUS_W");
   end
   if (ADDR_W > BUS_W) begin : g_bad_addr
      $error("hwloop_seq: ADDR_W exceeds BUS_W");
   end

   loop_act_e         act;
   logic [CNT_W-1:0]  count;
   logic [ADDR_W-1:0] end_addr;
   logic [ADDR_W-1:0] stk_top;

   hwloop_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
      .end_addr(end_addr), .count(count), .do_start(do_start), .stk_top(stk_top),
      .act(act), .next_pc(next_pc), .loop_flag(loop_flag), .nest_flag(nest_flag)
   );

   hwloop_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .act(act), .do_last(do_last), .do_count(do_count),
      .cnt_wr(cnt_wr), .end_wr(end_wr), .mv_wdata(mv_wdata), .count(count),
      .end_addr(end_addr), .cnt_rdata(cnt_rdata), .end_rdata(end_rdata)
   );

   hwloop_stack #(.DEPTH(STK_DEPTH), .W(ADDR_W)) u_stack (
      .clk(clk), .rst_n(rst_n), .push(act == ACT_START), .pop(act == ACT_EXIT),
      .din(do_first), .top(stk_top), .level(stk_level), .err(stk_err)
   );
endmodule

// File: rtl/hwloop_seq_chk.sv
module hwloop_seq_chk #(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 13,
   parameter int BUS_W     = 16,
   parameter int STK_DEPTH = 2
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           fetch_en,
   input logic [ADDR_W-1:0]              fetch_addr,
   input logic [ADDR_W-1:0]              next_pc,
   input logic                           do_start,
   input logic [CNT_W-1:0]               do_count,
   input logic                           cnt_wr,
   input logic [BUS_W-1:0]               mv_wdata,
   input logic [BUS_W-1:0]               cnt_rdata,
   input logic [BUS_W-1:0]               end_rdata,
   input logic                           loop_flag,
   input logic                           nest_flag,
   input logic [$clog2(STK_DEPTH+1)-1:0] stk_level,
   input logic                           stk_err
);
   logic             hit;
   logic [CNT_W-1:0] cnt_now;

   assign hit     = fetch_en && loop_flag && (fetch_addr == end_rdata[ADDR_W-1:0]);
   assign cnt_now = cnt_rdata[CNT_W-1:0];

   AST_NEXT_INC: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_flag |-> next_pc == ADDR_W'(fetch_addr + 1'b1)); // R4

   AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && !do_start) |=> cnt_now == $past(mv_wdata[CNT_W-1:0])); // R2

   AST_REPEAT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !do_start && !cnt_wr && cnt_now != CNT_W'(1))
      |=> cnt_now == CNT_W'($past(cnt_now) - 1'b1)); // R5

   AST_EXIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !do_start && cnt_now == CNT_W'(1)) |=> loop_flag == $past(nest_flag)); // R6

   AST_START_NEST: assert property (@(posedge clk) disable iff (!rst_n)
      do_start |=> loop_flag && nest_flag == $past(loop_flag)); // R7

   AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (do_start && do_count == '0) |=> cnt_now == CNT_W'(1)); // R8

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stk_err |=> stk_err); // R9

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      stk_level <= ($clog2(STK_DEPTH+1))'(STK_DEPTH)); // R9
endmodule

bind hwloop_seq hwloop_seq_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUS_W(BUS_W), .STK_DEPTH(STK_DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
   .next_pc(next_pc), .do_start(do_start), .do_count(do_count), .cnt_wr(cnt_wr),
   .mv_wdata(mv_wdata), .cnt_rdata(cnt_rdata), .end_rdata(end_rdata),
   .loop_flag(loop_flag), .nest_flag(nest_flag), .stk_level(stk_level),
   .stk_err(stk_err)
);

// File: tb/hwloop_seq_test.sv
module hwloop_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_en = 1'b0;
   logic [15:0] fetch_addr = '0;
   logic [15:0] next_pc;
   logic        do_start = 1'b0;
   logic [15:0] do_first = '0;
   logic [15:0] do_last = '0;
   logic [12:0] do_count = '0;
   logic        cnt_wr = 1'b0;
   logic        end_wr = 1'b0;
   logic [15:0] mv_wdata = '0;
   logic [15:0] cnt_rdata;
   logic [15:0] end_rdata;
   logic        loop_flag;
   logic        nest_flag;
   logic [1:0]  stk_level;
   logic        stk_err;

   int n_checks = 0;
   int n_fail   = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   hwloop_seq uut (
      .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
      .next_pc(next_pc), .do_start(do_start), .do_first(do_first), .do_last(do_last),
      .do_count(do_count), .cnt_wr(cnt_wr), .end_wr(end_wr), .mv_wdata(mv_wdata),
      .cnt_rdata(cnt_rdata), .end_rdata(end_rdata), .loop_flag(loop_flag),
      .nest_flag(nest_flag), .stk_level(stk_level), .stk_err(stk_err)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      fetch_en = 1'b0; do_start = 1'b0; cnt_wr = 1'b0; end_wr = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic start_loop(input logic [15:0] first, input logic [15:0] last,
                             input logic [12:0] n);
      do_start = 1'b1; do_first = first; do_last = last; do_count = n;
      step();
      do_start = 1'b0;
   endtask

   task automatic fetch(input logic [15:0] a, output logic [15:0] np);
      fetch_en = 1'b1; fetch_addr = a;
      #1 np = next_pc;
      step();
      fetch_en = 1'b0;
   endtask

   task automatic mv_write(input logic to_cnt, input logic [15:0] d);
      cnt_wr = to_cnt; end_wr = !to_cnt; mv_wdata = d;
      step();
      cnt_wr = 1'b0; end_wr = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1", "count", cnt_rdata, 0);
      check("R1", "last addr", end_rdata, 0);
      check("R1", "flag", loop_flag, 0);
      check("R1", "nest", nest_flag, 0);
      check("R1", "level", stk_level, 0);
      check("R1", "err", stk_err, 0);
      fetch_addr = 16'h0005; #1;
      check("R4", "idle next_pc", next_pc, 16'h0006);
      @(negedge clk);
   endtask

   task automatic t_move();
      do_reset();
      mv_write(1'b1, 16'hFFFF);
      check("R2", "count upper bits dropped", cnt_rdata, 16'h1FFF);
      mv_write(1'b1, 16'hA005);
      check("R2", "count write low bits", cnt_rdata, 16'h0005);
      mv_write(1'b0, 16'h1234);
      check("R3", "last addr move write", end_rdata, 16'h1234);
   endtask

   task automatic t_single();
      logic [15:0] np;
      do_reset();
      start_loop(16'h0010, 16'h0012, 13'd3);
      check("R7", "flag set", loop_flag, 1);
      check("R7", "nest saved", nest_flag, 0);
      check("R7", "pushed", stk_level, 1);
      check("R7", "count loaded", cnt_rdata, 3);
      check("R3", "last addr loaded", end_rdata, 16'h0012);
      fetch(16'h0011, np);
      check("R4", "body next_pc", np, 16'h0012);
      fetch_en = 1'b0; fetch_addr = 16'h0012; step();
      check("R4", "no fetch no decrement", cnt_rdata, 3);
      fetch(16'h0012, np);
      check("R5", "jump back 1", np, 16'h0010);
      check("R5", "count 3->2", cnt_rdata, 2);
      fetch(16'h0012, np);
      check("R5", "jump back 2", np, 16'h0010);
      check("R5", "count 2->1", cnt_rdata, 1);
      fetch(16'h0012, np);
      check("R6", "fall through", np, 16'h0013);
      check("R6", "flag from nest", loop_flag, 0);
      check("R6", "popped", stk_level, 0);
      check("R6", "count stays 1", cnt_rdata, 1);
      fetch(16'h0012, np);
      check("R4", "inactive at last addr", np, 16'h0013);
   endtask

   task automatic t_zero();
      logic [15:0] np;
      do_reset();
      start_loop(16'h0040, 16'h0044, 13'd0);
      check("R8", "zero count loads 1", cnt_rdata, 1);
      fetch(16'h0044, np);
      check("R8", "single pass exits", np, 16'h0045);
      check("R8", "popped", stk_level, 0);
   endtask

   task automatic t_nested();
      logic [15:0] np;
      do_reset();
      start_loop(16'h0020, 16'h0030, 13'd2);
      start_loop(16'h0022, 16'h0025, 13'd2);
      check("R7", "nest bit from flag", nest_flag, 1);
      check("R7", "two entries", stk_level, 2);
      fetch(16'h0025, np);
      check("R5", "inner jump", np, 16'h0022);
      fetch(16'h0025, np);
      check("R6", "inner exit", np, 16'h0026);
      check("R6", "flag restored from nest", loop_flag, 1);
      check("R6", "one entry left", stk_level, 1);
      check("R11", "count not restored", cnt_rdata, 1);
      check("R11", "last addr not restored", end_rdata, 16'h0025);
      mv_write(1'b0, 16'h0030);
      mv_write(1'b1, 16'h0002);
      fetch(16'h0030, np);
      check("R5", "outer jump to outer start", np, 16'h0020);
      fetch(16'h0030, np);
      check("R6", "outer exit", np, 16'h0031);
      check("R6", "stack empty", stk_level, 0);
      check("R9", "no error yet", stk_err, 0);
      mv_write(1'b1, 16'h0001);
      fetch(16'h0030, np);
      check("R9", "pop empty sets err", stk_err, 1);
      check("R9", "level stays 0", stk_level, 0);
   endtask

   task automatic t_overflow();
      logic [15:0] np;
      do_reset();
      start_loop(16'h0100, 16'h01FF, 13'd4);
      start_loop(16'h0200, 16'h02FF, 13'd4);
      check("R9", "full without err", stk_err, 0);
      start_loop(16'h0300, 16'h0040, 13'd5);
      check("R9", "push full sets err", stk_err, 1);
      check("R9", "level stays 2", stk_level, 2);
      fetch(16'h0040, np);
      check("R9", "top unchanged", np, 16'h0200);
      step();
      check("R9", "err sticky", stk_err, 1);
   endtask

   task automatic t_priority();
      logic [15:0] np;
      do_reset();
      start_loop(16'h0050, 16'h0058, 13'd1);
      fetch_en = 1'b1; fetch_addr = 16'h0058;
      do_start = 1'b1; do_first = 16'h0060; do_last = 16'h0068; do_count = 13'd7;
      #1 check("R10", "start beats exit next_pc", next_pc, 16'h0059);
      step();
      fetch_en = 1'b0; do_start = 1'b0;
      check("R10", "no pop on start", stk_level, 2);
      check("R10", "nest from flag", nest_flag, 1);
      check("R10", "start count", cnt_rdata, 7);
      do_reset();
      start_loop(16'h0070, 16'h0072, 13'd4);
      cnt_wr = 1'b1; mv_wdata = 16'h000A;
      fetch(16'h0072, np);
      cnt_wr = 1'b0;
      check("R10", "repeat still jumps", np, 16'h0070);
      check("R10", "write beats decrement", cnt_rdata, 16'h000A);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_move();
      t_single();
      t_zero();
      t_nested();
      t_overflow();
      t_priority();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule